// File: doc/BRIEF.md
# Three-Channel Prescaled Interval Timer

This peripheral holds three independent up-counting timer channels behind a word-addressed read/write register bus. Each channel takes one of two per-cycle tick inputs as its time base, optionally divides it by a power of two, and counts on the divided rate. A channel either runs free across its full width or, in interval mode, returns to zero after it has reached a programmed limit. The return to zero raises a status flag, which drives a level interrupt output when it is enabled.

Software stops and resumes a channel with a hold bit. A self-clearing write bit returns the count and the divider phase to zero. Reading a channel's status register returns its pending flag and clears the flag in the same access, so one read both reports and acknowledges the interrupt. Read data is registered and appears in the cycle after the read strobe.

Top module: `tri_tick_timer`

## Requirements
- R1: After reset every channel is held (hold bit reads 1), the clock control register reads 0, the interval register reads all ones at the counter width, and the count, status and enable registers read 0.
- R2: Register byte offsets are: clock control 0x00, counter control 0x0C, count 0x18, interval 0x24, status 0x54 and interrupt enable 0x60. Channel n's copy of each register is at its offset plus 4·n.
- R3: Clock control bit 0 enables the divider and bits 4:1 hold a value N. With the divider on, the count advances once per 2^(N+1) selected ticks. With it off, the count advances on every selected tick.
- R4: Clock control bit 5 picks the time base: 0 uses src_a_tick and 1 uses src_b_tick. The unselected input has no effect.
- R5: While counter control bit 0 (hold) is 1, the count keeps its value. Writing the bit to 0 resumes counting from that held value.
- R6: A counter control write with bit 4 set clears the count and the divider phase in that cycle. Bit 4 always reads back as 0, and bits 1:0 read back as written.
- R7: In free-running mode (counter control bit 1 = 0), the count goes from all ones to zero on the next advance.
- R8: In interval mode (counter control bit 1 = 1), an advance taken while the count equals the interval register sets the count to zero and sets status bit 0.
- R9: Channel interrupt output n is high exactly when that channel's status bit 0 and interrupt enable bit 0 are both 1.
- R10: A status read returns the flag as it was before the read and clears it. When a new wrap event falls in the same cycle as the read, the flag stays set.
- R11: Writes to the count and status registers have no effect.
- R12: Read data is valid in the cycle after bus_rd. In every other cycle it is 0, as it is for unmapped addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_a_tick | input | 1 | Time base A, one tick per high cycle |
| src_b_tick | input | 1 | Time base B, one tick per high cycle |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq | output | NUM_CH | Level interrupt, one per channel |

## Verification
The counters are driven by bursts of known length on one tick input at a time, with the divider off, at divide-by-2 and at divide-by-8. Comparing the final counts separates a wrong divisor from an off-by-one in the divider phase, and shows whether the unselected input leaks into the channel.

An interval limit of 3 shows where the wrap happens and when the flag goes up. A limit of 0 with ticks held high places a wrap event in the same cycle as a status read, which separates "event wins" from "clear wins". A full 16-bit free run tests the rollover. A behavioural model checks the interrupt outputs and the read data on every cycle.

// File: rtl/tt_pkg.sv
package tt_pkg;
   localparam int OFF_CLK  = 'h00;
   localparam int OFF_CTL  = 'h0C;
   localparam int OFF_CNT  = 'h18;
   localparam int OFF_INTV = 'h24;
   localparam int OFF_STAT = 'h54;
   localparam int OFF_IE   = 'h60;
   localparam int CH_STRIDE = 4;

   localparam int EXP_W        = 4;
   localparam int CLK_EN_BIT   = 0;
   localparam int CLK_EXP_LSB  = 1;
   localparam int CLK_SEL_BIT  = CLK_EXP_LSB + EXP_W;
   localparam int CTL_HOLD_BIT = 0;
   localparam int CTL_MODE_BIT = 1;
   localparam int CTL_RST_BIT  = 4;
   localparam int IE_BIT       = 0;

   typedef struct packed {
      logic clk_r;
      logic ctl_r;
      logic intv_r;
      logic ie_r;
   } wr_strobes_t;
endpackage

// File: rtl/tt_prescaler.sv
module tt_prescaler #(
   parameter int EXP_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             run,
   input  logic             en,
   input  logic [EXP_W-1:0] exp_sel,
   input  logic             clr,
   output logic             step
);
   localparam int DIV_W = 2 ** EXP_W;

   logic [DIV_W-1:0] phase_q;
   logic [DIV_W:0]   limit;
   logic             at_limit;

   always_comb begin
      limit    = ({{DIV_W{1'b0}}, 1'b1} << ({1'b0, exp_sel} + 1'b1)) - 1'b1;
      at_limit = ({1'b0, phase_q} >= limit);
      step     = run & tick & (~en | at_limit);
   end

   always_ff @(posedge clk) begin
      if (!rst_n || clr)
         phase_q <= '0;
      else if (run && tick && en)
         phase_q <= at_limit ? '0 : phase_q + 1'b1;
   end
endmodule

// File: rtl/tt_counter.sv
module tt_counter #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step,
   input  logic             wrap_mode,
   input  logic [CNT_W-1:0] limit,
   input  logic             clr,
   output logic [CNT_W-1:0] value,
   output logic             wrap_evt
);
   logic [CNT_W-1:0] value_q;

   assign wrap_evt = step & wrap_mode & (value_q == limit);
   assign value    = value_q;

   always_ff @(posedge clk) begin
      if (!rst_n || clr)
         value_q <= '0;
      else if (wrap_evt)
         value_q <= '0;
      else if (step)
         value_q <= value_q + 1'b1;
   end
endmodule

// File: rtl/tt_channel.sv
module tt_channel
   import tt_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             src_a,
   input  logic             src_b,
   input  wr_strobes_t      wr,
   input  logic             rd_stat,
   input  logic [31:0]      wdata,
   output logic [31:0]      rv_clk,
   output logic [31:0]      rv_ctl,
   output logic [31:0]      rv_cnt,
   output logic [31:0]      rv_intv,
   output logic [31:0]      rv_stat,
   output logic [31:0]      rv_ie,
   output logic             irq,
   output logic             evt,
   output logic             flag,
   output logic             hold,
   output logic [CNT_W-1:0] cnt
);
   logic             src_sel_q, pre_en_q, hold_q, mode_q, ie_q, flag_q;
   logic [EXP_W-1:0] pre_exp_q;
   logic [CNT_W-1:0] intv_q;
   logic             tick, step, cnt_clr;

   assign tick    = src_sel_q ? src_b : src_a;
   assign cnt_clr = wr.ctl_r & wdata[CTL_RST_BIT];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         src_sel_q <= 1'b0;
         pre_en_q  <= 1'b0;
         pre_exp_q <= '0;
         hold_q    <= 1'b1;
         mode_q    <= 1'b0;
         intv_q    <= '1;
         ie_q      <= 1'b0;
      end else begin
         if (wr.clk_r) begin
            src_sel_q <= wdata[CLK_SEL_BIT];
            pre_en_q  <= wdata[CLK_EN_BIT];
            pre_exp_q <= wdata[CLK_EXP_LSB +: EXP_W];
         end
         if (wr.ctl_r) begin
            hold_q <= wdata[CTL_HOLD_BIT];
            mode_q <= wdata[CTL_MODE_BIT];
         end
         if (wr.intv_r)
            intv_q <= wdata[CNT_W-1:0];
         if (wr.ie_r)
            ie_q <= wdata[IE_BIT];
      end
   end

   tt_prescaler #(.EXP_W(EXP_W)) u_pre (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (tick),
      .run     (~hold_q),
      .en      (pre_en_q),
      .exp_sel (pre_exp_q),
      .clr     (cnt_clr),
      .step    (step)
   );

   tt_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk       (clk),
      .rst_n     (rst_n),
      .step      (step),
      .wrap_mode (mode_q),
      .limit     (intv_q),
      .clr       (cnt_clr),
      .value     (cnt),
      .wrap_evt  (evt)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)
         flag_q <= 1'b0;
      else if (evt)
         flag_q <= 1'b1;
      else if (rd_stat)
         flag_q <= 1'b0;
   end

   always_comb begin
      rv_clk = '0;
      rv_clk[CLK_EN_BIT]              = pre_en_q;
      rv_clk[CLK_EXP_LSB +: EXP_W]    = pre_exp_q;
      rv_clk[CLK_SEL_BIT]             = src_sel_q;
      rv_ctl = '0;
      rv_ctl[CTL_HOLD_BIT]            = hold_q;
      rv_ctl[CTL_MODE_BIT]            = mode_q;
      rv_cnt  = 32'(cnt);
      rv_intv = 32'(intv_q);
      rv_stat = {31'd0, flag_q};
      rv_ie   = '0;
      rv_ie[IE_BIT]                   = ie_q;
   end

   assign irq  = flag_q & ie_q;
   assign flag = flag_q;
   assign hold = hold_q;
endmodule

// File: rtl/tri_tick_timer.sv
module tri_tick_timer
   import tt_pkg::*;
#(
   parameter int NUM_CH = 3,
   parameter int CNT_W  = 16,
   parameter int ADDR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              src_a_tick,
   input  logic              src_b_tick,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic [NUM_CH-1:0] irq
);
   localparam int TOP_ADDR = OFF_IE + CH_STRIDE * (NUM_CH - 1);

   if (!(CNT_W == 16 || CNT_W == 32)) begin : g_bad_width
      $error("CNT_W must be 16 or 32");
   end
   if (NUM_CH < 1 || NUM_CH > 3) begin : g_bad_count
      $error("NUM_CH must be 1 to 3 so banks do not overlap");
   end
   if (TOP_ADDR >= (1 << ADDR_W)) begin : g_bad_addr
      $error("ADDR_W too narrow for the register map");
   end

   logic [31:0] rv_clk  [NUM_CH];
   logic [31:0] rv_ctl  [NUM_CH];
   logic [31:0] rv_cnt  [NUM_CH];
   logic [31:0] rv_intv [NUM_CH];
   logic [31:0] rv_stat [NUM_CH];
   logic [31:0] rv_ie   [NUM_CH];

   logic [NUM_CH-1:0]       evt_v, flag_v, hold_v;
   logic [NUM_CH*CNT_W-1:0] cnt_v;
   logic [31:0]             rmux;

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      localparam logic [ADDR_W-1:0] A_CLK  = ADDR_W'(OFF_CLK  + CH_STRIDE * c);
      localparam logic [ADDR_W-1:0] A_CTL  = ADDR_W'(OFF_CTL  + CH_STRIDE * c);
      localparam logic [ADDR_W-1:0] A_INTV = ADDR_W'(OFF_INTV + CH_STRIDE * c);
      localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFF_STAT + CH_STRIDE * c);
      localparam logic [ADDR_W-1:0] A_IE   = ADDR_W'(OFF_IE   + CH_STRIDE * c);

      wr_strobes_t wr_s;
      logic        rd_s;

      always_comb begin
         wr_s.clk_r  = bus_wr && (bus_addr == A_CLK);
         wr_s.ctl_r  = bus_wr && (bus_addr == A_CTL);
         wr_s.intv_r = bus_wr && (bus_addr == A_INTV);
         wr_s.ie_r   = bus_wr && (bus_addr == A_IE);
         rd_s        = bus_rd && (bus_addr == A_STAT);
      end

      tt_channel #(.CNT_W(CNT_W)) u_chan (
         .clk     (clk),
         .rst_n   (rst_n),
         .src_a   (src_a_tick),
         .src_b   (src_b_tick),
         .wr      (wr_s),
         .rd_stat (rd_s),
         .wdata   (bus_wdata),
         .rv_clk  (rv_clk[c]),
         .rv_ctl  (rv_ctl[c]),
         .rv_cnt  (rv_cnt[c]),
         .rv_intv (rv_intv[c]),
         .rv_stat (rv_stat[c]),
         .rv_ie   (rv_ie[c]),
         .irq     (irq[c]),
         .evt     (evt_v[c]),
         .flag    (flag_v[c]),
         .hold    (hold_v[c]),
         .cnt     (cnt_v[c*CNT_W +: CNT_W])
      );
   end

   always_comb begin
      rmux = '0;
      for (int c = 0; c < NUM_CH; c++) begin
         if (bus_addr == ADDR_W'(OFF_CLK  + CH_STRIDE * c)) rmux = rv_clk[c];
         if (bus_addr == ADDR_W'(OFF_CTL  + CH_STRIDE * c)) rmux = rv_ctl[c];
         if (bus_addr == ADDR_W'(OFF_CNT  + CH_STRIDE * c)) rmux = rv_cnt[c];
         if (bus_addr == ADDR_W'(OFF_INTV + CH_STRIDE * c)) rmux = rv_intv[c];
         if (bus_addr == ADDR_W'(OFF_STAT + CH_STRIDE * c)) rmux = rv_stat[c];
         if (bus_addr == ADDR_W'(OFF_IE   + CH_STRIDE * c)) rmux = rv_ie[c];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         bus_rdata <= '0;
      else
         bus_rdata <= bus_rd ? rmux : 32'd0;
   end
endmodule

// File: rtl/tt_checker.sv
module tt_checker
   import tt_pkg::*;
#(
   parameter int NUM_CH = 3,
   parameter int CNT_W  = 16,
   parameter int ADDR_W = 8
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic [ADDR_W-1:0]       bus_addr,
   input logic                    bus_wr,
   input logic                    bus_rd,
   input logic [31:0]             bus_wdata,
   input logic [31:0]             bus_rdata,
   input logic [NUM_CH-1:0]       irq,
   input logic [NUM_CH-1:0]       evt_v,
   input logic [NUM_CH-1:0]       flag_v,
   input logic [NUM_CH-1:0]       hold_v,
   input logic [NUM_CH*CNT_W-1:0] cnt_v
);
   a_r12_idle_rdata_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rd |=> bus_rdata == 32'd0);

   for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
      localparam logic [ADDR_W-1:0] A_CTL  = ADDR_W'(OFF_CTL  + CH_STRIDE * c);
      localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFF_STAT + CH_STRIDE * c);
      localparam logic [ADDR_W-1:0] A_IE   = ADDR_W'(OFF_IE   + CH_STRIDE * c);

      a_r8_event_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
         evt_v[c] |=> flag_v[c]);

      a_r10_read_clears_flag: assert property (@(posedge clk) disable iff (!rst_n)
         (bus_rd && bus_addr == A_STAT && !evt_v[c]) |=> !flag_v[c]);

      a_r6_reset_zeroes_count: assert property (@(posedge clk) disable iff (!rst_n)
         (bus_wr && bus_addr == A_CTL && bus_wdata[CTL_RST_BIT])
            |=> cnt_v[c*CNT_W +: CNT_W] == '0);

      a_r5_hold_keeps_count: assert property (@(posedge clk) disable iff (!rst_n)
         (hold_v[c] && !(bus_wr && bus_addr == A_CTL))
            |=> $stable(cnt_v[c*CNT_W +: CNT_W]));

      a_r9_irq_falls_on_ack: assert property (@(posedge clk) disable iff (!rst_n)
         $fell(irq[c]) |-> $past((bus_rd && bus_addr == A_STAT) ||
                                 (bus_wr && bus_addr == A_IE)));
   end
endmodule

bind tri_tick_timer tt_checker #(
   .NUM_CH (NUM_CH),
   .CNT_W  (CNT_W),
   .ADDR_W (ADDR_W)
) u_tt_checker (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_addr  (bus_addr),
   .bus_wr    (bus_wr),
   .bus_rd    (bus_rd),
   .bus_wdata (bus_wdata),
   .bus_rdata (bus_rdata),
   .irq       (irq),
   .evt_v     (evt_v),
   .flag_v    (flag_v),
   .hold_v    (hold_v),
   .cnt_v     (cnt_v)
);

// File: tb/tri_tick_timer_test.sv
`timescale 1ns/1ps
module tri_tick_timer_test;
   localparam int NCH = 3;
   localparam int CW  = 16;
   localparam logic [31:0] CMASK = 32'h0000_FFFF;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        src_a = 1'b0, src_b = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic        bus_wr = 1'b0, bus_rd = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [NCH-1:0] irq;

   int n_chk = 0, n_fail = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   tri_tick_timer #(.NUM_CH(NCH), .CNT_W(CW), .ADDR_W(8)) uut (
      .clk(clk), .rst_n(rst_n), .src_a_tick(src_a), .src_b_tick(src_b),
      .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq));

   // behavioural reference model
   bit [31:0] m_cnt[NCH], m_intv[NCH], m_div[NCH];
   bit        m_hold[NCH], m_mode[NCH], m_pen[NCH], m_sel[NCH], m_ie[NCH], m_flag[NCH];
   bit [3:0]  m_n[NCH];
   bit [31:0] m_rdata;

   function automatic bit [31:0] model_read(input bit [7:0] a);
      bit [31:0] r = 0;
      for (int c = 0; c < NCH; c++) begin
         if (a == 8'(8'h00 + 4*c)) r = {26'd0, m_sel[c], m_n[c], m_pen[c]};
         if (a == 8'(8'h0C + 4*c)) r = {30'd0, m_mode[c], m_hold[c]};
         if (a == 8'(8'h18 + 4*c)) r = m_cnt[c];
         if (a == 8'(8'h24 + 4*c)) r = m_intv[c];
         if (a == 8'(8'h54 + 4*c)) r = {31'd0, m_flag[c]};
         if (a == 8'(8'h60 + 4*c)) r = {31'd0, m_ie[c]};
      end
      return r;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int c = 0; c < NCH; c++) begin
            m_cnt[c] = 0; m_intv[c] = CMASK; m_div[c] = 0; m_hold[c] = 1;
            m_mode[c] = 0; m_pen[c] = 0; m_sel[c] = 0; m_ie[c] = 0;
            m_flag[c] = 0; m_n[c] = 0;
         end
         m_rdata = 0;
      end else begin
         m_rdata = bus_rd ? model_read(bus_addr) : 32'd0;
         for (int c = 0; c < NCH; c++) begin
            bit tk, st, ev;
            int lim;
            tk = m_sel[c] ? src_b : src_a;
            st = 0; ev = 0;
            if (!m_hold[c] && tk) begin
               if (m_pen[c]) begin
                  lim = (1 << (m_n[c] + 1)) - 1;
                  if (m_div[c] >= 32'(lim)) begin m_div[c] = 0; st = 1; end
                  else m_div[c] = m_div[c] + 1;
               end else st = 1;
            end
            if (st) begin
               if (m_mode[c] && m_cnt[c] == m_intv[c]) begin m_cnt[c] = 0; ev = 1; end
               else m_cnt[c] = (m_cnt[c] + 1) & CMASK;
            end
            if (ev) m_flag[c] = 1;
            else if (bus_rd && bus_addr == 8'(8'h54 + 4*c)) m_flag[c] = 0;
            if (bus_wr) begin
               if (bus_addr == 8'(8'h00 + 4*c)) begin
                  m_pen[c] = bus_wdata[0]; m_n[c] = bus_wdata[4:1]; m_sel[c] = bus_wdata[5];
               end
               if (bus_addr == 8'(8'h0C + 4*c)) begin
                  m_hold[c] = bus_wdata[0]; m_mode[c] = bus_wdata[1];
                  if (bus_wdata[4]) begin m_cnt[c] = 0; m_div[c] = 0; end
               end
               if (bus_addr == 8'(8'h24 + 4*c)) m_intv[c] = bus_wdata & CMASK;
               if (bus_addr == 8'(8'h60 + 4*c)) m_ie[c] = bus_wdata[0];
            end
         end
      end
   end

   task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   // every-cycle comparison against the model
   always @(negedge clk) begin
      if (rst_n && !done) begin
         check(bus_rdata === m_rdata, "R12 rdata vs model", bus_rdata, m_rdata);
         for (int c = 0; c < NCH; c++)
            check(irq[c] === (m_flag[c] & m_ie[c]), "R9 irq vs model",
                  32'(irq[c]), 32'(m_flag[c] & m_ie[c]));
      end
   end

   task automatic wr(input bit [7:0] a, input bit [31:0] d);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input bit [7:0] a, input bit [31:0] exp, input string tag);
      bus_addr = a; bus_rd = 1'b1;
      @(negedge clk);
      bus_rd = 1'b0;
      check(bus_rdata === exp, tag, bus_rdata, exp);
   endtask

   task automatic ticks(input bit a, input bit b, input int n);
      src_a = a; src_b = b;
      repeat (n) @(negedge clk);
      src_a = 1'b0; src_b = 1'b0;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      check(1'b0, "watchdog expired", 32'd0, 32'd1);
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      rd(8'h0C, 32'h1,    "R1 ctl ch0 held");
      rd(8'h04, 32'h0,    "R1 clk ctl ch1");
      rd(8'h2C, 32'hFFFF, "R1 interval ch2");
      rd(8'h18, 32'h0,    "R1 count ch0");
      rd(8'h58, 32'h0,    "R1 status ch1");
      rd(8'h68, 32'h0,    "R1 enable ch2");
      @(negedge clk);
      check(bus_rdata === 0, "R12 idle rdata", bus_rdata, 0);
      // R2 banking
      wr(8'h24, 32'h11); wr(8'h28, 32'h22); wr(8'h2C, 32'h33);
      rd(8'h24, 32'h11, "R2 interval ch0");
      rd(8'h28, 32'h22, "R2 interval ch1");
      rd(8'h2C, 32'h33, "R2 interval ch2");
      wr(8'h04, 32'h20);
      rd(8'h04, 32'h20, "R2 clk ctl ch1");
      rd(8'h00, 32'h00, "R2 clk ctl ch0 untouched");
      // R3 divider
      wr(8'h00, 32'h01);
      wr(8'h0C, 32'h10);
      rd(8'h0C, 32'h0, "R6 reset bit reads 0");
      ticks(1, 0, 10);
      rd(8'h18, 32'd5, "R3 divide by 2");
      wr(8'h00, 32'h05);
      wr(8'h0C, 32'h10);
      ticks(1, 0, 24);
      rd(8'h18, 32'd3, "R3 divide by 8");
      // R4 source select, R5 hold
      wr(8'h10, 32'h10);
      ticks(1, 0, 7);
      rd(8'h1C, 32'd0, "R4 unselected source ignored");
      ticks(0, 1, 4);
      rd(8'h1C, 32'd4, "R4 selected source counts");
      wr(8'h10, 32'h01);
      ticks(0, 1, 5);
      rd(8'h1C, 32'd4, "R5 held count");
      wr(8'h10, 32'h00);
      ticks(0, 1, 2);
      rd(8'h1C, 32'd6, "R5 resumes from held value");
      // R8 interval mode, R9, R10
      wr(8'h2C, 32'd3);
      wr(8'h68, 32'h1);
      wr(8'h14, 32'h12);
      rd(8'h14, 32'h2, "R6 mode bit kept, reset bit 0");
      ticks(1, 0, 3);
      check(irq[2] === 1'b0, "R8 no flag before limit", 32'(irq[2]), 0);
      rd(8'h20, 32'd3, "R8 count at limit");
      ticks(1, 0, 1);
      check(irq[2] === 1'b1, "R8 flag on wrap", 32'(irq[2]), 1);
      rd(8'h20, 32'd0, "R8 count wrapped to 0");
      rd(8'h5C, 32'h1, "R10 status read returns flag");
      check(irq[2] === 1'b0, "R10 read cleared flag", 32'(irq[2]), 0);
      rd(8'h5C, 32'h0, "R10 status stays clear");
      wr(8'h68, 32'h0);
      ticks(1, 0, 4);
      check(irq[2] === 1'b0, "R9 masked irq", 32'(irq[2]), 0);
      wr(8'h68, 32'h1);
      check(irq[2] === 1'b1, "R9 pending flag unmasked", 32'(irq[2]), 1);
      rd(8'h5C, 32'h1, "R10 clear pending");
      // R10 collision: event in same cycle as read
      wr(8'h2C, 32'd0);
      wr(8'h14, 32'h12);
      src_a = 1'b1;
      @(negedge clk);
      rd(8'h5C, 32'h1, "R10 read during events");
      src_a = 1'b0;
      check(irq[2] === 1'b1, "R10 event wins over clear", 32'(irq[2]), 1);
      rd(8'h5C, 32'h1, "R10 flag kept by event");
      rd(8'h5C, 32'h0, "R10 flag cleared after");
      // R11 read-only registers
      wr(8'h1C, 32'hABCD);
      rd(8'h1C, 32'd6, "R11 count write ignored");
      wr(8'h58, 32'h1);
      rd(8'h58, 32'h0, "R11 status write ignored");
      // R7 free-running rollover
      wr(8'h00, 32'h00);
      wr(8'h0C, 32'h10);
      ticks(1, 0, 65535);
      rd(8'h18, 32'hFFFF, "R7 count at all ones");
      ticks(1, 0, 1);
      rd(8'h18, 32'h0, "R7 rollover to zero");
      rd(8'h40, 32'h0, "R12 unmapped reads 0");
      @(negedge clk);
      finish_run();
   end
endmodule